// File: doc/BRIEF.md
# MCU Reset Sequencer

This block gathers the three reasons an 8-bit microcontroller core may need to restart: an active-low external reset pin, a reset request from the watchdog, and a reset request from the low-voltage detector. Whichever source fires, the block holds the core in reset, waits a fixed stabilisation time counted in internal clock cycles, then steps through a two-cycle read of the reset vector before it lets the core run.

While the core is in reset the block tells it to clear its hardware stack. During the vector read it drives the program counter load and the fetch address. It also keeps an interrupt-mode flag set, so the core's start-up code runs in non-maskable mode. That flag is dropped only when the core reports that a return-from-interrupt instruction has completed. A small register records which source caused the most recent reset.

Top module: `mcu_reset_sequencer`

## Requirements
- R1: While any reset source is active (pin low, `wdg_req` high or `lvd_req` high), `core_rst` is high and `run` is low.
- R2: After the last clock edge at which a request is seen, the block stays in reset for exactly `DELAY_CYCLES` (default 2048) clock cycles. The first fetch cycle follows at edge L+1+DELAY_CYCLES.
- R3: The vector fetch lasts two cycles. In the first, `pc_addr` is 0xFFE and both `pc_load` and `fetch_rd` are high. In the second, `pc_addr` is 0xFFF, `fetch_rd` is high and `pc_load` is low.
- R4: `run` rises in the cycle after the second fetch cycle and is low in every reset state, including both fetch cycles.
- R5: `stack_clr` is high while a request is held and during the delay, and low while running.
- R6: `nmi_mode` is high in every reset state and is still high when `run` first rises.
- R7: `nmi_mode` falls one cycle after `reti_done` is sampled high while running. `reti_done` has no effect during reset. If a reset request arrives in the same cycle as `reti_done`, the reset wins and `nmi_mode` stays high.
- R8: A new request during the delay or during either fetch cycle returns the block to reset and restarts the delay count from zero.
- R9: The pin is synchronised through two flops, so a pin release is seen two edges later. A falling pin forces reset at once, without waiting for a clock edge.
- R10: `rst_cause` encodes 01 for the pin, 10 for the watchdog and 11 for low voltage. When sources are active together, low voltage takes priority over watchdog, and watchdog over the pin. The value holds until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdg_req | input | 1 | Watchdog reset request, synchronous |
| lvd_req | input | 1 | Low-voltage reset request, synchronous |
| reti_done | input | 1 | Core reports completion of a return-from-interrupt |
| core_rst | output | 1 | Holds the core in reset |
| stack_clr | output | 1 | Clears the core's hardware stack |
| pc_load | output | 1 | Loads the program counter from `pc_addr` |
| fetch_rd | output | 1 | Read strobe for the vector fetch |
| pc_addr | output | 12 | Vector fetch address, zero outside the fetch |
| run | output | 1 | Core is running |
| nmi_mode | output | 1 | Non-maskable interrupt mode flag |
| rst_cause | output | 2 | Source of the last reset |

## Verification
The collision of interest is a reset request and a `reti_done` sampled on the same clock edge. Flag clearing and flag setting then compete for `nmi_mode`. The bench drives `wdg_req` and `reti_done` together while the core is running, and requires `nmi_mode` to be high in the very next cycle. A second overlap is a request landing on the first fetch cycle. There the bench expects the 0xFFE read to appear, the 0xFFF read never to appear, and the scoreboard to then take only the rescheduled fetch pair.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_DELAY  = 3'd1,
    ST_FETCH0 = 3'd2,
    ST_FETCH1 = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    CAUSE_PIN = 2'b01,
    CAUSE_WDG = 2'b10,
    CAUSE_LVD = 2'b11
  } cause_t;

  // Priority: low voltage, then watchdog, then pin.
  function automatic cause_t pick_cause(input logic pin, input logic wdg, input logic lvd);
    if (lvd)      return CAUSE_LVD;
    else if (wdg) return CAUSE_WDG;
    else if (pin) return CAUSE_PIN;
    else          return CAUSE_PIN;
  endfunction

  // True when the delay counter sits on its final cycle.
  function automatic logic delay_last(input int unsigned cnt, input int unsigned len);
    return cnt == (len - 1);
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic released
);
  logic [STAGES-1:0] sh;

  generate
    genvar i;
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) sh[0] <= 1'b0;
          else         sh[0] <= 1'b1;
      end else begin : g_rest
        always_ff @(posedge clk or negedge arst_n)
          if (!arst_n) sh[i] <= 1'b0;
          else         sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign released = sh[STAGES-1];
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic   clk,
  input  logic   arst_n,
  input  logic   pin_req,
  input  logic   wdg_req,
  input  logic   lvd_req,
  output cause_t cause
);
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                           cause <= CAUSE_PIN;
    else if (pin_req || wdg_req || lvd_req) cause <= pick_cause(pin_req, wdg_req, lvd_req);
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
  import rstseq_pkg::*;
#(
  parameter int                 DELAY_CYCLES = 2048,
  parameter int                 ADDR_W       = 12,
  parameter logic [ADDR_W-1:0]  VEC_ADDR     = 12'hFFE
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              req,
  output seq_state_t        state,
  output logic              stack_clr,
  output logic              pc_load,
  output logic              fetch_rd,
  output logic [ADDR_W-1:0] pc_addr,
  output logic              run
);
  localparam int CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;

  logic [CNT_W-1:0] cnt;
  logic             cnt_end;

  assign cnt_end = delay_last(int'(cnt), DELAY_CYCLES);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else if (req) begin
      state <= ST_HOLD;
      cnt   <= '0;
    end else begin
      case (state)
        ST_HOLD: begin
          state <= ST_DELAY;
          cnt   <= '0;
        end
        ST_DELAY: begin
          if (cnt_end) state <= ST_FETCH0;
          else         cnt   <= cnt + 1'b1;
        end
        ST_FETCH0: state <= ST_FETCH1;
        ST_FETCH1: state <= ST_RUN;
        ST_RUN:    state <= ST_RUN;
        default:   state <= ST_HOLD;
      endcase
    end
  end

  always_comb begin
    stack_clr = (state == ST_HOLD) || (state == ST_DELAY);
    pc_load   = (state == ST_FETCH0);
    fetch_rd  = (state == ST_FETCH0) || (state == ST_FETCH1);
    run       = (state == ST_RUN);
    case (state)
      ST_FETCH0: pc_addr = VEC_ADDR;
      ST_FETCH1: pc_addr = VEC_ADDR + 1'b1;
      default:   pc_addr = '0;
    endcase
  end
endmodule

// File: rtl/rstseq_nmi.sv
module rstseq_nmi (
  input  logic clk,
  input  logic arst_n,
  input  logic in_reset,
  input  logic req,
  input  logic reti_done,
  output logic nmi_mode
);
  // A request or any reset state sets the flag; a completed return clears it only while running.
  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)              nmi_mode <= 1'b1;
    else if (in_reset || req) nmi_mode <= 1'b1;
    else if (reti_done)       nmi_mode <= 1'b0;
endmodule

// File: rtl/mcu_reset_sequencer.sv
module mcu_reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int                DELAY_CYCLES = 2048,
  parameter int                SYNC_STAGES  = 2,
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] VEC_ADDR     = 12'hFFE
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              wdg_req,
  input  logic              lvd_req,
  input  logic              reti_done,
  output logic              core_rst,
  output logic              stack_clr,
  output logic              pc_load,
  output logic              fetch_rd,
  output logic [ADDR_W-1:0] pc_addr,
  output logic              run,
  output logic              nmi_mode,
  output logic [1:0]        rst_cause
);
  logic       pin_released;
  logic       pin_req;
  logic       any_req;
  logic       delay_active;
  seq_state_t state;
  cause_t     cause;

  rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .arst_n(ext_rst_n), .released(pin_released)
  );

  assign pin_req = ~pin_released;
  assign any_req = pin_req | wdg_req | lvd_req;

  rstseq_fsm #(.DELAY_CYCLES(DELAY_CYCLES), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_fsm (
    .clk(clk), .arst_n(ext_rst_n), .req(any_req), .state(state),
    .stack_clr(stack_clr), .pc_load(pc_load), .fetch_rd(fetch_rd),
    .pc_addr(pc_addr), .run(run)
  );

  rstseq_cause u_cause (
    .clk(clk), .arst_n(ext_rst_n), .pin_req(pin_req),
    .wdg_req(wdg_req), .lvd_req(lvd_req), .cause(cause)
  );

  rstseq_nmi u_nmi (
    .clk(clk), .arst_n(ext_rst_n), .in_reset(state != ST_RUN),
    .req(any_req), .reti_done(reti_done), .nmi_mode(nmi_mode)
  );

  assign delay_active = (state == ST_DELAY);
  assign core_rst     = ~run;
  assign rst_cause    = cause;
endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk #(
  parameter int                DELAY_CYCLES = 2048,
  parameter int                ADDR_W       = 12,
  parameter logic [ADDR_W-1:0] VEC_ADDR     = 12'hFFE
) (
  input logic              clk,
  input logic              ext_rst_n,
  input logic              wdg_req,
  input logic              lvd_req,
  input logic              reti_done,
  input logic              core_rst,
  input logic              stack_clr,
  input logic              pc_load,
  input logic              fetch_rd,
  input logic [ADDR_W-1:0] pc_addr,
  input logic              run,
  input logic              nmi_mode,
  input logic [1:0]        rst_cause,
  input logic              delay_active,
  input logic              any_req
);
  localparam int WIN_W = $clog2(DELAY_CYCLES + 1) + 1;
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n)        win_q <= '0;
    else if (delay_active) win_q <= win_q + 1'b1;
    else                   win_q <= '0;

  p_req_holds_r1: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wdg_req || lvd_req) |=> (core_rst && !run));

  p_delay_win_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    delay_active |-> (win_q < WIN_W'(DELAY_CYCLES)));

  p_delay_len_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    pc_load |-> (win_q == WIN_W'(DELAY_CYCLES)));

  p_fetch_order_r3: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (pc_load && !any_req) |=> (fetch_rd && !pc_load && pc_addr == VEC_ADDR + 1'b1));

  p_run_after_fetch_r4: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (fetch_rd && !pc_load && !any_req) |=> run);

  p_stack_clr_r5: assert property (@(posedge clk) disable iff (!ext_rst_n)
    delay_active |-> (stack_clr && !run));

  p_nmi_set_r6: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(run) |-> nmi_mode);

  p_nmi_clear_r7: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (run && reti_done && !any_req) |=> !nmi_mode);

  p_nmi_reset_wins_r7: assert property (@(posedge clk) disable iff (!ext_rst_n)
    any_req |=> nmi_mode);

  p_restart_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (delay_active && (wdg_req || lvd_req)) |=> (stack_clr && !delay_active));

  p_cause_prio_r10: assert property (@(posedge clk) disable iff (!ext_rst_n)
    lvd_req |=> (rst_cause == 2'b11));
endmodule

bind mcu_reset_sequencer rstseq_chk #(
  .DELAY_CYCLES(DELAY_CYCLES), .ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)
) u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .wdg_req(wdg_req), .lvd_req(lvd_req),
  .reti_done(reti_done), .core_rst(core_rst), .stack_clr(stack_clr),
  .pc_load(pc_load), .fetch_rd(fetch_rd), .pc_addr(pc_addr), .run(run),
  .nmi_mode(nmi_mode), .rst_cause(rst_cause), .delay_active(delay_active),
  .any_req(any_req)
);

// File: tb/sim_mcu_reset_sequencer.sv
`timescale 1ns/1ps
module sim_mcu_reset_sequencer;
  localparam int DLY = 2048;

  logic        clk = 1'b0;
  logic        ext_rst_n = 1'b0;
  logic        wdg_req = 1'b0;
  logic        lvd_req = 1'b0;
  logic        reti_done = 1'b0;
  logic        core_rst, stack_clr, pc_load, fetch_rd, run, nmi_mode;
  logic [11:0] pc_addr;
  logic [1:0]  rst_cause;

  mcu_reset_sequencer u0 (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdg_req(wdg_req), .lvd_req(lvd_req),
    .reti_done(reti_done), .core_rst(core_rst), .stack_clr(stack_clr),
    .pc_load(pc_load), .fetch_rd(fetch_rd), .pc_addr(pc_addr), .run(run),
    .nmi_mode(nmi_mode), .rst_cause(rst_cause)
  );

  always #2 clk = ~clk;

  typedef struct { int cyc; logic [11:0] addr; } fetch_t;
  fetch_t q[$];

  int  cyc = 0;
  int  tests = 0;
  int  fails = 0;
  int  exp_run = 0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // Monitor: compares every fetch cycle against the scoreboard.
  always @(negedge clk) begin
    if (fetch_rd && !done) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected fetch", int'(pc_addr), 0);
      end else begin
        fetch_t f;
        f = q.pop_front();
        chk(cyc == f.cyc, "R2 fetch cycle", cyc, f.cyc);
        chk(pc_addr == f.addr, "R3 fetch address", int'(pc_addr), int'(f.addr));
        chk(pc_load == (f.addr == 12'hFFE), "R3 pc_load", int'(pc_load), int'(f.addr == 12'hFFE));
        chk(!run, "R4 run low in fetch", int'(run), 0);
      end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // Driver: schedule the fetch pair that follows last request edge L.
  task automatic expect_seq(input int last_edge);
    fetch_t f;
    q.delete();
    f.cyc = last_edge + 1 + DLY; f.addr = 12'hFFE; q.push_back(f);
    f.cyc = last_edge + 2 + DLY; f.addr = 12'hFFF; q.push_back(f);
    exp_run = last_edge + 3 + DLY;
  endtask

  task automatic pulse(input bit w, input bit l, output int last_edge);
    wdg_req = w; lvd_req = l;
    last_edge = cyc + 1;
    step();
    wdg_req = 1'b0; lvd_req = 1'b0;
  endtask

  task automatic wait_run();
    while (cyc < exp_run - 1) step();
    chk(!run && fetch_rd, "R4 run low in last fetch", int'(run), 0);
    step();
    chk(run && !core_rst, "R4 run high after fetch", int'(run), 1);
    chk(nmi_mode, "R6 nmi high at run start", int'(nmi_mode), 1);
    chk(!stack_clr, "R5 stack_clr low in run", int'(stack_clr), 0);
  endtask

  initial begin
    int le;
    repeat (3) step();
    chk(core_rst && !run, "R1 pin held reset", int'(run), 0);
    chk(stack_clr, "R5 stack_clr in reset", int'(stack_clr), 1);
    chk(nmi_mode, "R6 nmi in reset", int'(nmi_mode), 1);
    chk(rst_cause == 2'b01, "R10 cause pin", int'(rst_cause), 1);
    chk(!fetch_rd && pc_addr == 12'h000, "R3 no fetch in reset", int'(pc_addr), 0);

    // R9: pin release seen two edges later
    ext_rst_n = 1'b1;
    expect_seq(cyc + 2);
    wait_run();
    chk(rst_cause == 2'b01, "R10 cause pin kept", int'(rst_cause), 1);

    // R7: reti while running clears flag
    reti_done = 1'b1; step(); reti_done = 1'b0;
    chk(!nmi_mode, "R7 nmi cleared by reti", int'(nmi_mode), 0);

    // Watchdog reset
    pulse(1'b1, 1'b0, le);
    expect_seq(le);
    chk(core_rst && !run, "R1 watchdog reset", int'(run), 0);
    repeat (4) step();
    chk(nmi_mode, "R6 nmi set by reset", int'(nmi_mode), 1);
    chk(stack_clr, "R5 stack_clr during delay", int'(stack_clr), 1);
    chk(rst_cause == 2'b10, "R10 cause watchdog", int'(rst_cause), 2);
    reti_done = 1'b1; step(); reti_done = 1'b0; step();
    chk(nmi_mode, "R7 reti ignored in reset", int'(nmi_mode), 1);
    wait_run();

    // R8: restart mid-delay
    pulse(1'b0, 1'b1, le);
    expect_seq(le);
    repeat (1000) step();
    pulse(1'b1, 1'b0, le);
    expect_seq(le);
    chk(stack_clr && !run, "R8 restart in delay", int'(run), 0);
    wait_run();
    chk(rst_cause == 2'b10, "R10 last cause kept", int'(rst_cause), 2);

    // R10: simultaneous low voltage and watchdog
    pulse(1'b1, 1'b1, le);
    expect_seq(le);
    chk(rst_cause == 2'b11, "R10 lvd over watchdog", int'(rst_cause), 3);
    wait_run();

    // R8: request on the first fetch cycle
    pulse(1'b1, 1'b0, le);
    expect_seq(le);
    while (cyc < le + 1 + DLY) step();
    chk(q.size() == 1, "R3 first fetch seen", q.size(), 1);
    pulse(1'b1, 1'b0, le);
    expect_seq(le);
    chk(!fetch_rd && stack_clr, "R8 abort in fetch", int'(fetch_rd), 0);
    wait_run();

    // R7: reset and reti collide in the same cycle
    wdg_req = 1'b1; reti_done = 1'b1;
    le = cyc + 1;
    step();
    wdg_req = 1'b0; reti_done = 1'b0;
    chk(nmi_mode, "R7 reset wins over reti", int'(nmi_mode), 1);
    expect_seq(le);
    wait_run();

    // R9: asynchronous pin assertion
    ext_rst_n = 1'b0;
    #0.5;
    chk(core_rst && !run, "R9 async pin assert", int'(run), 0);
    chk(rst_cause == 2'b01, "R10 cause pin async", int'(rst_cause), 1);
    q.delete();
    step();
    chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual=hung expected=finished", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule